// File: doc/BRIEF.md
# HDLC Receive Byte FIFO with End-of-Packet Tagging

This block sits between the bit-level HDLC receive engine and the host-side reader. The engine hands it one byte at a time. Along with each byte comes a 2-bit tag. A zero tag means an ordinary data byte. A non-zero tag marks the final byte of a frame and says how the frame ended. The block keeps up to 128 such tagged entries. On the other side, the host pulls bytes out one per request. A look-ahead output warns the host when the byte at the head closes a frame.

If the engine offers a byte while the store is already full, the block reports an overflow and stops taking bytes. Any bytes offered after that are dropped without a report. Reception resumes once the engine signals that it has seen a flag. At every accepted frame end, the block copies the two CRC bytes that the engine presents into two holding registers. They are copied bit for bit, exactly as they arrived on the line.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: After synchronous reset the block is empty (level 0), reception is enabled, and the following are all 0: `rd_valid`, `rd_empty_err`, `ovf_pulse`, `eop_next`, `crc_hi` and `crc_lo`.
- R2: Bytes come out in the order they were accepted. Up to 128 entries are held. A read result appears on `rd_data`/`rd_tag` with `rd_valid` high, one cycle after `rd_req`.
- R3: When a byte is offered while reception is enabled and 128 entries are held, three things happen. `ovf_pulse` goes high for exactly the next cycle. `rx_enabled` goes low in that same cycle. The stored contents and the level do not change.
- R4: While `rx_enabled` is low, offered bytes are discarded. They cause no overflow pulse, no level change and no CRC capture.
- R5: A `flag_seen` pulse while reception is disabled raises `rx_enabled` on the next cycle. If the store has not been read since, the next offered byte overflows again.
- R6: The tag is stored with its byte and returned on `rd_tag`. The codes are: 00 data, 01 frame closed by a good flag, 10 frame aborted, 11 invalid frame.
- R7: `eop_next` is high exactly when the store is not empty and the head entry carries a non-zero tag.
- R8: A read request on an empty store gives three results on the next cycle: `rd_data` = 0, `rd_tag` = 0, and a one-cycle `rd_empty_err` pulse. `rd_valid` stays low and the level stays at 0.
- R9: When a byte with a non-zero tag is accepted, the values of `crc_hi_in` and `crc_lo_in` are copied unchanged into `crc_hi` and `crc_lo`, visible on the next cycle. At all other times those two registers hold their value.
- R10: `fifo_level` reports the number of stored entries. An accepted write together with a successful read in the same cycle leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Byte offered by the receive engine |
| in_data | input | 8 | Offered byte |
| in_tag | input | 2 | End-of-frame tag of the offered byte |
| flag_seen | input | 1 | Engine detected a flag; re-enables reception |
| crc_hi_in | input | 8 | Received CRC upper byte from the engine |
| crc_lo_in | input | 8 | Received CRC lower byte from the engine |
| rd_req | input | 1 | Host read request |
| rd_data | output | 8 | Read byte |
| rd_tag | output | 2 | Tag of the read byte |
| rd_valid | output | 1 | rd_data/rd_tag hold a stored entry |
| rd_empty_err | output | 1 | Read was attempted on an empty store |
| eop_next | output | 1 | Head entry is the last byte of a frame |
| ovf_pulse | output | 1 | Overflow occurred |
| rx_enabled | output | 1 | Reception currently accepted |
| fifo_level | output | 8 | Number of stored entries |
| crc_hi | output | 8 | Captured CRC upper byte |
| crc_lo | output | 8 | Captured CRC lower byte |

## Verification
The hardest state to reach is a second overflow after a flag, when no byte has been read in between. Getting there requires a completely full store, a lockout, a dropped end-of-frame byte and a re-enable, all in sequence. The stimulus first fills all 128 entries through the write task, with a tag on every sixteenth byte. It then offers a tagged byte to trigger the overflow and checks that the CRC registers did not move. Next it pulses the flag and offers another byte, then reads a single entry, re-enables, and refills to the limit. Finally it drains the whole store against the scoreboard.

// File: rtl/hdlc_rx_fifo_pkg.sv
package hdlc_rx_fifo_pkg;
  localparam int TAG_W = 2;

  typedef enum logic [TAG_W-1:0] {
    TAG_DATA  = 2'b00,
    TAG_GOOD  = 2'b01,
    TAG_ABORT = 2'b10,
    TAG_BAD   = 2'b11
  } eop_tag_e;
endpackage

// File: rtl/hdlc_rx_gate.sv
module hdlc_rx_gate (
  input  logic clk,
  input  logic rst,
  input  logic in_vld,
  input  logic flag_seen,
  input  logic fifo_full,
  output logic wr_en,
  output logic rx_en,
  output logic ovf_pulse
);
  logic ovf_hit;

  assign ovf_hit = in_vld && rx_en && fifo_full;
  assign wr_en   = in_vld && rx_en && !fifo_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en     <= 1'b1;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= ovf_hit;
      if (ovf_hit)
        rx_en <= 1'b0;
      else if (flag_seen)
        rx_en <= 1'b1;
    end
  end

  a_r3_lockout: assert property (@(posedge clk) disable iff (rst)
    (in_vld && rx_en && fifo_full) |=> (ovf_pulse && !rx_en));

  a_r5_reenable: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && flag_seen) |=> rx_en);

  a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !ovf_pulse);
endmodule

// File: rtl/hdlc_rx_store.sv
module hdlc_rx_store #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  parameter int TAG_W  = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  output logic              empty_rd,
  output logic              head_eop,
  output logic              full,
  output logic              empty,
  output logic [CW-1:0]     level
);
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic              do_rd;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign level    = count;
  assign do_rd    = rd_en && !empty;
  assign head_eop = !empty && (tag_mem[rd_ptr] != '0);

  // Data array: write port and registered read, no reset (block RAM friendly)
  always_ff @(posedge clk) begin
    if (wr_en) data_mem[wr_ptr] <= wr_data;
  end

  // Tag array: small, read asynchronously for the look-ahead flag
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_ptr] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_tag   <= '0;
      rd_valid <= 1'b0;
      empty_rd <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      empty_rd <= rd_en && empty;
      if (do_rd) begin
        rd_data <= data_mem[rd_ptr];
        rd_tag  <= tag_mem[rd_ptr];
      end else if (rd_en) begin
        rd_data <= '0;
        rd_tag  <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en)
        wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd)
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);

  a_r10_level_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  a_r10_level_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !do_rd) |=> (count == $past(count) + 1'b1));

  a_r8_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> (empty_rd && rd_data == '0 && rd_tag == '0 && !rd_valid));

  a_r2_read_valid: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !empty) |=> (rd_valid && !empty_rd));
endmodule

// File: rtl/hdlc_rx_crc_latch.sv
module hdlc_rx_crc_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= '0;
      lo <= '0;
    end else if (cap) begin
      hi <= hi_in;
      lo <= lo_in;
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !cap |=> ($stable(hi) && $stable(lo)));

  a_r9_take: assert property (@(posedge clk) disable iff (rst)
    cap |=> (hi == $past(hi_in) && lo == $past(lo_in)));
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
  import hdlc_rx_fifo_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              flag_seen,
  input  logic [DATA_W-1:0] crc_hi_in,
  input  logic [DATA_W-1:0] crc_lo_in,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  output logic              rd_empty_err,
  output logic              eop_next,
  output logic              ovf_pulse,
  output logic              rx_enabled,
  output logic [CW-1:0]     fifo_level,
  output logic [DATA_W-1:0] crc_hi,
  output logic [DATA_W-1:0] crc_lo
);
  logic wr_en, full, empty, cap;

  hdlc_rx_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .flag_seen (flag_seen),
    .fifo_full (full),
    .wr_en     (wr_en),
    .rx_en     (rx_enabled),
    .ovf_pulse (ovf_pulse)
  );

  hdlc_rx_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (in_data),
    .wr_tag   (in_tag),
    .rd_en    (rd_req),
    .rd_data  (rd_data),
    .rd_tag   (rd_tag),
    .rd_valid (rd_valid),
    .empty_rd (rd_empty_err),
    .head_eop (eop_next),
    .full     (full),
    .empty    (empty),
    .level    (fifo_level)
  );

  assign cap = wr_en && (in_tag != TAG_DATA);

  hdlc_rx_crc_latch #(.W(DATA_W)) u_crc (
    .clk   (clk),
    .rst   (rst),
    .cap   (cap),
    .hi_in (crc_hi_in),
    .lo_in (crc_lo_in),
    .hi    (crc_hi),
    .lo    (crc_lo)
  );

  a_r7_eop_needs_data: assert property (@(posedge clk) disable iff (rst)
    eop_next |-> (fifo_level != '0));

  a_r4_drop_keeps_level: assert property (@(posedge clk) disable iff (rst)
    (!rx_enabled && !rd_req) |=> $stable(fifo_level));
endmodule

// File: tb/hdlc_rx_fifo_tb.sv
`timescale 1ns/1ps
module hdlc_rx_fifo_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, in_vld, flag_seen, rd_req;
  logic [7:0] in_data, crc_hi_in, crc_lo_in;
  logic [1:0] in_tag;
  logic [7:0] rd_data, crc_hi, crc_lo, fifo_level;
  logic [1:0] rd_tag;
  logic       rd_valid, rd_empty_err, eop_next, ovf_pulse, rx_enabled;

  hdlc_rx_fifo u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data), .in_tag(in_tag),
    .flag_seen(flag_seen), .crc_hi_in(crc_hi_in), .crc_lo_in(crc_lo_in),
    .rd_req(rd_req), .rd_data(rd_data), .rd_tag(rd_tag), .rd_valid(rd_valid),
    .rd_empty_err(rd_empty_err), .eop_next(eop_next), .ovf_pulse(ovf_pulse),
    .rx_enabled(rx_enabled), .fifo_level(fifo_level), .crc_hi(crc_hi), .crc_lo(crc_lo)
  );

  typedef struct packed { logic [7:0] d; logic [1:0] t; } item_t;
  item_t sb[$];
  item_t exp_item;
  int checks = 0;
  int errors = 0;
  int model_level = 0;
  bit model_en = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: every valid read is compared against the scoreboard head
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2", "unexpected read", int'(rd_data), 0);
      end else begin
        exp_item = sb.pop_front();
        chk(rd_data == exp_item.d, "R2", "rd_data order", int'(rd_data), int'(exp_item.d));
        chk(rd_tag == exp_item.t, "R6", "rd_tag", int'(rd_tag), int'(exp_item.t));
      end
    end
  end

  task automatic wr(input logic [7:0] d, input logic [1:0] t,
                    input logic [7:0] ch, input logic [7:0] cl);
    bit exp_ovf, accepted;
    logic [7:0] h0, l0;
    exp_ovf  = model_en && (model_level == 128);
    accepted = model_en && (model_level < 128);
    h0 = crc_hi; l0 = crc_lo;
    in_vld = 1'b1; in_data = d; in_tag = t; crc_hi_in = ch; crc_lo_in = cl;
    @(negedge clk);
    in_vld = 1'b0; in_tag = 2'b00;
    if (accepted) begin sb.push_back({d, t}); model_level++; end
    if (exp_ovf) model_en = 1'b0;
    chk(ovf_pulse == exp_ovf, "R3", "ovf_pulse", int'(ovf_pulse), int'(exp_ovf));
    chk(rx_enabled == model_en, "R4", "rx_enabled", int'(rx_enabled), int'(model_en));
    chk(fifo_level == model_level, "R10", "fifo_level", int'(fifo_level), model_level);
    if (accepted && t != 2'b00) begin
      chk(crc_hi == ch, "R9", "crc_hi capture", int'(crc_hi), int'(ch));
      chk(crc_lo == cl, "R9", "crc_lo capture", int'(crc_lo), int'(cl));
    end else begin
      chk(crc_hi == h0 && crc_lo == l0, "R9", "crc hold", int'({crc_hi, crc_lo}), int'({h0, l0}));
    end
  endtask

  task automatic rd();
    bit exp_empty;
    exp_empty = (model_level == 0);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    if (!exp_empty) model_level--;
    chk(rd_empty_err == exp_empty, "R8", "rd_empty_err", int'(rd_empty_err), int'(exp_empty));
    if (exp_empty) begin
      chk(rd_data == 8'h00 && rd_tag == 2'b00, "R8", "empty read data", int'({rd_data, rd_tag}), 0);
      chk(rd_valid == 1'b0, "R8", "empty read valid", int'(rd_valid), 0);
    end
    chk(fifo_level == model_level, "R10", "level after read", int'(fifo_level), model_level);
  endtask

  task automatic flag();
    flag_seen = 1'b1;
    @(negedge clk);
    flag_seen = 1'b0;
    model_en = 1'b1;
    chk(rx_enabled == 1'b1, "R5", "re-enable on flag", int'(rx_enabled), 1);
  endtask

  initial begin
    #750000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; in_vld = 1'b0; in_data = '0; in_tag = '0; flag_seen = 1'b0;
    crc_hi_in = '0; crc_lo_in = '0; rd_req = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(fifo_level == 0 && rx_enabled == 1'b1, "R1", "level/enable", int'({fifo_level, rx_enabled}), 1);
    chk(!rd_valid && !rd_empty_err && !ovf_pulse && !eop_next, "R1", "flags clear",
        int'({rd_valid, rd_empty_err, ovf_pulse, eop_next}), 0);
    chk(crc_hi == 0 && crc_lo == 0, "R1", "crc clear", int'({crc_hi, crc_lo}), 0);

    // R7 and R6: a short good frame, look-ahead flag tracks the head
    wr(8'h10, 2'b00, 8'h00, 8'h00);
    wr(8'h11, 2'b00, 8'h00, 8'h00);
    wr(8'h12, 2'b01, 8'hA5, 8'h3C);
    chk(eop_next == 1'b0, "R7", "head is data", int'(eop_next), 0);
    rd(); rd();
    chk(eop_next == 1'b1, "R7", "head is last byte", int'(eop_next), 1);
    rd();
    chk(eop_next == 1'b0, "R7", "empty store", int'(eop_next), 0);

    // R6: aborted and invalid frame endings
    wr(8'h20, 2'b00, 8'h00, 8'h00);
    wr(8'h21, 2'b10, 8'h81, 8'h7E);
    wr(8'h30, 2'b11, 8'hFF, 8'h01);
    chk(eop_next == 1'b0, "R7", "head data before abort", int'(eop_next), 0);
    rd(); rd(); rd();

    // R8: read on empty store
    rd();

    // R2/R3: fill to the limit, then overflow
    for (int i = 0; i < 128; i++)
      wr(8'(i), (i % 16 == 15) ? 2'b01 : 2'b00, 8'(i + 1), 8'(~i));
    chk(fifo_level == 128, "R2", "full level", int'(fifo_level), 128);
    wr(8'hEE, 2'b11, 8'hAA, 8'hBB);           // R3 overflow, R9 no capture
    wr(8'hEF, 2'b01, 8'hCC, 8'hDD);           // R4 dropped silently
    chk(eop_next == 1'b0, "R4", "head unchanged", int'(eop_next), 0);
    flag();                                    // R5 re-enable
    wr(8'hF0, 2'b00, 8'h00, 8'h00);           // R5 overflows again
    chk(rx_enabled == 1'b0, "R5", "second lockout", int'(rx_enabled), 0);
    rd();
    flag();
    wr(8'h55, 2'b01, 8'h12, 8'h34);           // accepted, refills to 128
    chk(fifo_level == 128, "R2", "refilled", int'(fifo_level), 128);
    repeat (128) rd();
    @(negedge clk);
    chk(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);

    // R10: simultaneous accepted write and read
    wr(8'h61, 2'b00, 8'h00, 8'h00);
    wr(8'h62, 2'b00, 8'h00, 8'h00);
    in_vld = 1'b1; in_data = 8'h63; in_tag = 2'b01; crc_hi_in = 8'h9A; crc_lo_in = 8'hBC;
    rd_req = 1'b1;
    sb.push_back({8'h63, 2'b01});
    @(negedge clk);
    in_vld = 1'b0; rd_req = 1'b0; in_tag = 2'b00;
    chk(fifo_level == 2, "R10", "level on read+write", int'(fifo_level), 2);
    chk(crc_hi == 8'h9A && crc_lo == 8'hBC, "R9", "capture during read", int'({crc_hi, crc_lo}), 16'h9ABC);
    model_level = 2;
    rd(); rd();
    @(negedge clk);
    chk(sb.size() == 0, "R2", "final drain", sb.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule